// File: doc/BRIEF.md
# Persistent Memory Region Control Registers

This block holds the control and status state for an optional persistent memory region in a storage controller. Software writes 32-bit words through a simple write port. A select code picks one of these: a control word that turns the region on or off, a read-only capability word, a read-only status word, and a low and a high word that together program a 64-bit base address for the region's memory space.

Every write passes through a capability gate. When the capability-present input is low, the block drops the write. The block drives three results: a region-enable level, the programmed base address with a flag that says the address has been accepted, and a two-bit status word.

When the low word asks for the memory space to be turned on, the block first adds the region size to the candidate base address. If that sum carries out of 64 bits, the address-invalid status bit is raised and the memory space stays off. If there is no carry, the base-valid flag rises. The backing memory and any flushing to persistent media are outside this block.

Top module: `pmr_ctrl_regs`

## Requirements
- R1: After reset, region_en_o is 0, base_valid_o is 0, base_addr_o is 0, and status_o is 2'b01. Bit 0 of status_o is not-ready and bit 1 is address-invalid.
- R2: While cap_present_i is 0, every write has no effect on any output, whatever the select code.
- R3: A control write (wr_sel_i = 1) with wr_data_i[0] = 1 sets region_en_o to 1 and clears status_o to 2'b00 on the next cycle.
- R4: A control write with wr_data_i[0] = 0 sets region_en_o to 0, sets status_o[0] to 1 and clears base_valid_o on the next cycle. status_o[1] keeps its value.
- R5: base_addr_o equals {high word, low word[31:12], 12'b0}. The high word is written with select 4 and the low word with select 3. Low-word bits 11:0 never appear in the address.
- R6: Any low-word write clears base_valid_o on the next cycle unless that same write passes R7. A low-word write with wr_data_i[1] = 0 leaves base_valid_o at 0.
- R7: A low-word write with wr_data_i[1] = 1 sets base_valid_o to 1 one cycle later when (new base + REGION_BYTES) fits below 2^64.
- R8: If that sum reaches or passes 2^64, the write sets status_o[1] to 1 one cycle later and base_valid_o stays 0.
- R9: Writes to select 0 (capability), select 2 (status) and the unused selects 5 to 7 change no output.
- R10: A high-word write updates base_addr_o but leaves base_valid_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cap_present_i | input | 1 | Region capability present; gates every write |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 3 | Register select: 0 capability, 1 control, 2 status, 3 low word, 4 high word |
| wr_data_i | input | 32 | Write data |
| region_en_o | output | 1 | Region enabled |
| base_addr_o | output | 64 | Programmed memory-space base address |
| base_valid_o | output | 1 | Memory-space base accepted and enabled |
| status_o | output | 2 | Bit 0 not-ready, bit 1 address-invalid |

## Verification
Every result of a write is registered, so each one is due exactly one clock after the edge that captures the write. This holds for region enable, status bits, base address, base-valid flag and the wrap flag alike. The bench drives each write on a falling edge and releases the strobe on the next falling edge. It then compares the outputs at that moment, one full edge after capture and away from any active edge. The wrap check is probed on both sides of the limit, including a sum that lands exactly on 2^64.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned SEL_W  = 3;
   localparam int unsigned NUM_SEL = 1 << SEL_W;

   localparam logic [SEL_W-1:0] SEL_CAP   = 3'd0;
   localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd1;
   localparam logic [SEL_W-1:0] SEL_STAT  = 3'd2;
   localparam logic [SEL_W-1:0] SEL_SPLO  = 3'd3;
   localparam logic [SEL_W-1:0] SEL_SPHI  = 3'd4;

   localparam int unsigned CTRL_EN_BIT  = 0;
   localparam int unsigned SPLO_REQ_BIT = 1;
   localparam int unsigned ST_NRDY_BIT  = 0;
   localparam int unsigned ST_AINV_BIT  = 1;

   typedef struct packed {
      logic ctrl;
      logic splo;
      logic sphi;
   } pmr_strb_t;
endpackage

// File: rtl/pmr_wr_decode.sv
module pmr_wr_decode
   import pmr_pkg::*;
(
   input  logic             wr_en_i,
   input  logic             cap_present_i,
   input  logic [SEL_W-1:0] wr_sel_i,
   output pmr_strb_t        strb_o
);
   logic [NUM_SEL-1:0] hit;

   generate
      for (genvar g = 0; g < NUM_SEL; g++) begin : g_hit
         assign hit[g] = wr_en_i && cap_present_i && (wr_sel_i == SEL_W'(g));
      end
   endgenerate

   // capability, status and unused selects have no strobe: writes vanish
   assign strb_o.ctrl = hit[SEL_CTRL];
   assign strb_o.splo = hit[SEL_SPLO];
   assign strb_o.sphi = hit[SEL_SPHI];

   // R2
   no_strobe_without_cap_chk: assert final (cap_present_i || (strb_o == '0));
endmodule

// File: rtl/pmr_wrap_check.sv
module pmr_wrap_check #(
   parameter logic [63:0] REGION_BYTES = 64'h0000_0000_0100_0000
) (
   input  logic [63:0] base_i,
   output logic        wrap_o
);
   logic [64:0] sum;

   generate
      if (REGION_BYTES == 64'd0) begin : g_bad_size
         initial $error("REGION_BYTES must be non-zero");
      end
   endgenerate

   assign sum    = {1'b0, base_i} + {1'b0, REGION_BYTES};
   assign wrap_o = sum[64];
endmodule

// File: rtl/pmr_space_regs.sv
module pmr_space_regs
   import pmr_pkg::*;
#(
   parameter int unsigned ADDR_SHIFT   = 12,
   parameter logic [63:0] REGION_BYTES = 64'h0000_0000_0100_0000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              lo_wr_i,
   input  logic              hi_wr_i,
   input  logic              kill_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [63:0]       base_addr_o,
   output logic              base_valid_o,
   output logic              wrap_hit_o
);
   localparam int unsigned FIELD_W = DATA_W - ADDR_SHIFT;

   generate
      if (ADDR_SHIFT <= SPLO_REQ_BIT || ADDR_SHIFT >= DATA_W) begin : g_bad_shift
         initial $error("ADDR_SHIFT must lie above the request bit and below DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0]  hi_q;
   logic [FIELD_W-1:0] lo_field_q;
   logic               valid_q;
   logic [63:0]        cand_base;
   logic               cand_wrap;

   assign cand_base = {hi_q, wr_data_i[DATA_W-1:ADDR_SHIFT], {ADDR_SHIFT{1'b0}}};

   pmr_wrap_check #(.REGION_BYTES(REGION_BYTES)) wrap_i (
      .base_i (cand_base),
      .wrap_o (cand_wrap)
   );

   assign wrap_hit_o = lo_wr_i && wr_data_i[SPLO_REQ_BIT] && cand_wrap;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hi_q       <= '0;
         lo_field_q <= '0;
         valid_q    <= 1'b0;
      end else begin
         if (hi_wr_i) hi_q <= wr_data_i;
         if (lo_wr_i) begin
            lo_field_q <= wr_data_i[DATA_W-1:ADDR_SHIFT];
            valid_q    <= wr_data_i[SPLO_REQ_BIT] && !cand_wrap;
         end else if (kill_i) begin
            valid_q    <= 1'b0;
         end
      end
   end

   assign base_addr_o  = {hi_q, lo_field_q, {ADDR_SHIFT{1'b0}}};
   assign base_valid_o = valid_q;

   // R6
   lo_no_req_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lo_wr_i && !wr_data_i[SPLO_REQ_BIT]) |=> !base_valid_o);
   // R7
   valid_rise_from_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(base_valid_o) |-> $past(lo_wr_i));
   // R10
   hi_keeps_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hi_wr_i && !kill_i) |=> $stable(base_valid_o));
endmodule

// File: rtl/pmr_ctrl_regs.sv
module pmr_ctrl_regs
   import pmr_pkg::*;
#(
   parameter int unsigned ADDR_SHIFT   = 12,
   parameter logic [63:0] REGION_BYTES = 64'h0000_0000_0100_0000
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        cap_present_i,
   input  logic        wr_en_i,
   input  logic [2:0]  wr_sel_i,
   input  logic [31:0] wr_data_i,
   output logic        region_en_o,
   output logic [63:0] base_addr_o,
   output logic        base_valid_o,
   output logic [1:0]  status_o
);
   pmr_strb_t strb;
   logic      ctrl_off;
   logic      wrap_hit;
   logic      en_q;
   logic [1:0] st_q;

   pmr_wr_decode dec_i (
      .wr_en_i       (wr_en_i),
      .cap_present_i (cap_present_i),
      .wr_sel_i      (wr_sel_i),
      .strb_o        (strb)
   );

   assign ctrl_off = strb.ctrl && !wr_data_i[CTRL_EN_BIT];

   pmr_space_regs #(.ADDR_SHIFT(ADDR_SHIFT), .REGION_BYTES(REGION_BYTES)) space_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .lo_wr_i      (strb.splo),
      .hi_wr_i      (strb.sphi),
      .kill_i       (ctrl_off),
      .wr_data_i    (wr_data_i),
      .base_addr_o  (base_addr_o),
      .base_valid_o (base_valid_o),
      .wrap_hit_o   (wrap_hit)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         en_q <= 1'b0;
         st_q <= 2'b01;
      end else if (strb.ctrl) begin
         if (wr_data_i[CTRL_EN_BIT]) begin
            en_q <= 1'b1;
            st_q <= 2'b00;
         end else begin
            en_q <= 1'b0;
            st_q[ST_NRDY_BIT] <= 1'b1;
         end
      end else if (wrap_hit) begin
         st_q[ST_AINV_BIT] <= 1'b1;
      end
   end

   assign region_en_o = en_q;
   assign status_o    = st_q;

   // R2
   no_cap_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_present_i |=> ($stable(region_en_o) && $stable(status_o)
                          && $stable(base_valid_o) && $stable(base_addr_o)));
   // R3
   ctrl_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && cap_present_i && wr_sel_i == SEL_CTRL && wr_data_i[0])
      |=> (region_en_o && status_o == 2'b00));
   // R4
   ctrl_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && cap_present_i && wr_sel_i == SEL_CTRL && !wr_data_i[0])
      |=> (!region_en_o && status_o[0] && !base_valid_o));
   // R8
   wrap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_o[1]) |-> !base_valid_o);
endmodule

// File: tb/pmr_ctrl_regs_tb_top.sv
module pmr_ctrl_regs_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap = 1'b1;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic        region_en;
   logic [63:0] base_addr;
   logic        base_valid;
   logic [1:0]  status;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   pmr_ctrl_regs dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .cap_present_i (cap),
      .wr_en_i       (wr_en),
      .wr_sel_i      (wr_sel),
      .wr_data_i     (wr_data),
      .region_en_o   (region_en),
      .base_addr_o   (base_addr),
      .base_valid_o  (base_valid),
      .status_o      (status)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 region_en", region_en, 0);
      chk("R1 base_valid", base_valid, 0);
      chk("R1 base_addr", base_addr, 0);
      chk("R1 status", status, 2'b01);
   endtask

   task automatic t_no_cap;
      cap = 1'b0;
      wr(3'd1, 32'h1);
      wr(3'd4, 32'hFFFF_FFFF);
      wr(3'd3, 32'hFE00_0002);
      chk("R2 region_en", region_en, 0);
      chk("R2 status", status, 2'b01);
      chk("R2 base_addr", base_addr, 0);
      chk("R2 base_valid", base_valid, 0);
      cap = 1'b1;
   endtask

   task automatic t_ctrl_on;
      wr(3'd1, 32'h1);
      chk("R3 region_en", region_en, 1);
      chk("R3 status", status, 2'b00);
   endtask

   task automatic t_compose;
      wr(3'd4, 32'h1234_5678);
      wr(3'd3, 32'h9ABC_DFFD);
      chk("R5 base_addr", base_addr, 64'h1234_5678_9ABC_D000);
      chk("R6 no request", base_valid, 0);
   endtask

   task automatic t_space_ok;
      wr(3'd4, 32'hFFFF_FFFF);
      wr(3'd3, 32'hFE00_0002);
      chk("R7 valid", base_valid, 1);
      chk("R7 status", status, 2'b00);
      wr(3'd3, 32'hFEFF_F002);
      chk("R7 valid near limit", base_valid, 1);
      chk("R5 base near limit", base_addr, 64'hFFFF_FFFF_FEFF_F000);
   endtask

   task automatic t_hi_keeps;
      wr(3'd4, 32'h0);
      chk("R10 valid kept", base_valid, 1);
      chk("R10 base", base_addr, 64'h0000_0000_FEFF_F000);
      wr(3'd3, 32'hFEFF_F000);
      chk("R6 cleared", base_valid, 0);
   endtask

   task automatic t_wrap;
      wr(3'd4, 32'hFFFF_FFFF);
      wr(3'd3, 32'hFF00_0002);
      chk("R8 exact 2^64 valid", base_valid, 0);
      chk("R8 exact 2^64 status", status, 2'b10);
      wr(3'd3, 32'hFFFF_F002);
      chk("R8 far wrap valid", base_valid, 0);
      chk("R8 far wrap status", status, 2'b10);
   endtask

   task automatic t_ro;
      wr(3'd2, 32'h0);
      wr(3'd0, 32'hFFFF_FFFF);
      for (int s = 5; s < 8; s++) wr(3'(s), 32'hFFFF_FFFF);
      chk("R9 status", status, 2'b10);
      chk("R9 region_en", region_en, 1);
      chk("R9 base", base_addr, 64'hFFFF_FFFF_FFFF_F000);
      chk("R9 valid", base_valid, 0);
   endtask

   task automatic t_ctrl_off;
      wr(3'd3, 32'hFE00_0002);
      chk("R7 valid again", base_valid, 1);
      wr(3'd1, 32'h0);
      chk("R4 region_en", region_en, 0);
      chk("R4 status", status, 2'b11);
      chk("R4 valid", base_valid, 0);
      wr(3'd1, 32'h1);
      chk("R3 re-enable status", status, 2'b00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_cap();
      t_ctrl_on();
      t_compose();
      t_space_ok();
      t_hi_keeps();
      t_wrap();
      t_ro();
      t_ctrl_off();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #200000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule